// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block models a synchronous static memory that accepts a new read or write on every rising clock edge. Reads and writes can follow each other in any order, and the data bus never needs an idle cycle to turn around. The array is 36 bits wide and is split into four 9-bit byte lanes. Each lane holds eight data bits and one parity bit. The number of words is a parameter.

A read returns its word one clock after its address is registered. A write takes its address on the first edge, and its data and lane enables two active edges later. A small pending-write pipeline covers the gap. When a read hits the pending write, it returns that write's data merged into the array word, lane by lane. Separate input and output buses replace a shared bidirectional bus. A valid flag marks the cycles in which the output carries read data.

A clock enable stalls the whole pipeline. Three chip enables qualify each new command. An advance/load input either starts a new command or continues the current one at the next address in a 4-beat group. The output enable is asynchronous and acts only on the output.

Top module: `zbt_sram`

## Requirements
- R1: A command is accepted on a rising edge with `cke_n` low, `adv_ld_n` low and the chip selected (`ce1_n`=0, `ce2`=1, `ce2_n`=0). `we_n`=1 makes it a read and `we_n`=0 makes it a write.
- R2: The read word appears on `dout`, with `dout_vld` high, in the cycle after the next active edge following the address edge.
- R3: For a write, `din` and `bw_n` are sampled on the second active edge after the address edge.
- R4: While `cke_n` is high, every input except `oe_n` is ignored. The array, the pipeline and the output register all hold their values.
- R5: On a write, lane i (bits 9i+8..9i) is written only when `bw_n[i]` is low. A write with `bw_n`=4'b1111 leaves the word unchanged.
- R6: `adv_ld_n` low without a chip select is a deselect and starts nothing. `adv_ld_n` high after a deselect keeps the block deselected.
- R7: `adv_ld_n` high after an accepted read or write repeats the same kind of command. The address keeps its upper bits, and its low two bits step by one modulo 4. A continued write with `bw_n`=4'b1111 still steps the address but writes nothing.
- R8: `oe_n` high forces `dout_vld` low and `dout` to zero at once. A read with `oe_n` high therefore delivers no data.
- R9: A read that reaches the array on the same edge where a pending write to that address takes its data returns the `din` lanes enabled by `bw_n` merged over the array word.
- R10: `dout_vld` is low in the cycle after a write, a deselect or a dummy read is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control pipeline |
| cke_n | input | 1 | Clock enable, active low |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce2_n | input | 1 | Chip enable, active low |
| adv_ld_n | input | 1 | Low: load a new command; high: continue the current one |
| we_n | input | 1 | Write enable, active low |
| bw_n | input | 4 | Lane write enables, active low, sampled with the write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | ADDR_W | Word address |
| din | input | 36 | Write data |
| dout | output | 36 | Read data, zero when not valid |
| dout_vld | output | 1 | Read data valid |

## Verification
Assertions check the following on every cycle: the freeze under a high clock enable, the output-enable gating, the step of the write pipeline, the low valid flag after a write, the persistence of a deselect, and the modulo-4 address step of a continued command. The bench scenarios alone show the data contents. These cover lane-merged forwarding when a read lands on the edge of a pending write, aborted writes leaving old words intact, and commands presented during a stall having no effect. They also cover the burst wrap from the last lane of a group back to its first.

// File: rtl/zbt_sram.sv
module zbt_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cke_n,
  input  logic                      ce1_n,
  input  logic                      ce2,
  input  logic                      ce2_n,
  input  logic                      adv_ld_n,
  input  logic                      we_n,
  input  logic [LANES-1:0]          bw_n,
  input  logic                      oe_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LANES*LANE_W-1:0]   din,
  output logic [LANES*LANE_W-1:0]   dout,
  output logic                      dout_vld
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // stage 1: accepted command (also the burst state); stage 2: write awaiting data
  logic              s1_v, s1_wr, s2_v, rd_q;
  logic [ADDR_W-1:0] s1_a, s2_a;
  logic [DATA_W-1:0] q, rd_word;

  wire sel  = ~ce1_n & ce2 & ~ce2_n;
  wire load = ~adv_ld_n;
  wire [ADDR_W-1:0] step_a = {s1_a[ADDR_W-1:2], s1_a[1:0] + 2'd1};
  wire              cmd_v  = load ? sel   : s1_v;
  wire              cmd_wr = load ? ~we_n : s1_wr;
  wire [ADDR_W-1:0] cmd_a  = load ? addr  : step_a;
  wire              fwd    = s2_v && (s2_a == s1_a);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rd_word[g*LANE_W +: LANE_W] =
      (fwd && !bw_n[g]) ? din[g*LANE_W +: LANE_W] : mem[s1_a][g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v  <= 1'b0;
      s1_wr <= 1'b0;
      s1_a  <= '0;
      s2_v  <= 1'b0;
      s2_a  <= '0;
      rd_q  <= 1'b0;
      q     <= '0;
    end else if (!cke_n) begin
      s1_v  <= cmd_v;
      s1_wr <= cmd_wr;
      s1_a  <= cmd_a;
      s2_v  <= s1_v & s1_wr;
      s2_a  <= s1_a;
      rd_q  <= s1_v & ~s1_wr;
      if (s1_v && !s1_wr) q <= rd_word;
    end
  end

  always_ff @(posedge clk) begin
    if (!cke_n && s2_v)
      for (int i = 0; i < LANES; i++)
        if (!bw_n[i]) mem[s2_a][i*LANE_W +: LANE_W] <= din[i*LANE_W +: LANE_W];
  end

  assign dout_vld = rd_q & ~oe_n;
  assign dout     = dout_vld ? q : '0;

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> $stable(rd_q) && $stable(q) && $stable(s2_v) && $stable(s1_a)); // R4
  AST_OE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!dout_vld && dout == '0)); // R8
  AST_WRITE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && s1_v && s1_wr) |=> !dout_vld); // R10
  AST_WRITE_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && s1_v && s1_wr) |=> (s2_v && s2_a == $past(s1_a))); // R3
  AST_READ_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && s1_v && !s1_wr) |=> rd_q); // R2
  AST_DESELECT_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && adv_ld_n && !s1_v) |=> !s1_v); // R6
  AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && adv_ld_n && s1_v) |=>
      (s1_v && s1_a[1:0] == 2'($past(s1_a[1:0]) + 2'd1)
       && s1_a[ADDR_W-1:2] == $past(s1_a[ADDR_W-1:2]))); // R7
endmodule

// File: tb/zbt_sram_tb_top.sv
module zbt_sram_tb_top;
  localparam int AW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cke_n = 1'b1, ce1_n = 1'b1, ce2 = 1'b0, ce2_n = 1'b1, adv_ld_n = 1'b0, we_n = 1'b1, oe_n = 1'b0;
  logic [3:0] bw_n = 4'hF;
  logic [AW-1:0] addr = '0;
  logic [35:0] din = '0;
  logic [35:0] dout;
  logic dout_vld;

  always #2.5 clk = ~clk;

  zbt_sram #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .ce1_n(ce1_n), .ce2(ce2), .ce2_n(ce2_n),
    .adv_ld_n(adv_ld_n), .we_n(we_n), .bw_n(bw_n), .oe_n(oe_n), .addr(addr),
    .din(din), .dout(dout), .dout_vld(dout_vld));

  typedef struct { int due; bit rd; logic [35:0] d; string tag; } item_t;
  item_t sb[$];
  int checks = 0, fails = 0, tick = 0;

  // bench reference state
  logic [35:0] ref_mem [64];
  bit m1_v, m1_wr, m2_v, last_rd;
  logic [AW-1:0] m1_a, m2_a;
  logic [35:0] last_d;

  function automatic logic [35:0] pat(int a);
    return {9'(a + 1), 9'(a * 3 + 7), 9'(a ^ 9'h155), 9'(9'h1F0 - a)};
  endfunction

  localparam logic [2:0] SEL = 3'b010;

  task automatic drive(bit ck, bit adv, logic [2:0] ce, bit we, logic [3:0] bw,
                       bit oe, logic [AW-1:0] a, logic [35:0] d, string tag);
    bit nv, nwr;
    logic [AW-1:0] na;
    logic [35:0] w;
    @(negedge clk);
    tick++;
    cke_n = ck; adv_ld_n = adv; {ce1_n, ce2, ce2_n} = ce; we_n = we; bw_n = bw;
    oe_n = oe; addr = a; din = d;
    if (!ck) begin
      nv  = adv ? m1_v  : (ce == SEL);
      nwr = adv ? m1_wr : !we;
      na  = adv ? {m1_a[AW-1:2], 2'(m1_a[1:0] + 2'd1)} : a;
      last_rd = m1_v && !m1_wr;
      if (last_rd) begin
        w = ref_mem[m1_a];
        if (m2_v && m2_a == m1_a)
          for (int i = 0; i < 4; i++) if (!bw[i]) w[i*9 +: 9] = d[i*9 +: 9];
        last_d = w;
      end
      if (m2_v)
        for (int i = 0; i < 4; i++) if (!bw[i]) ref_mem[m2_a][i*9 +: 9] = d[i*9 +: 9];
      m2_v = m1_v && m1_wr; m2_a = m1_a;
      m1_v = nv; m1_wr = nwr; m1_a = na;
    end
    sb.push_back('{tick + 1, last_rd, last_d, tag});
  endtask

  always @(negedge clk) begin
    item_t it;
    logic [35:0] ed;
    bit ev;
    #1;
    if (sb.size() > 0 && sb[0].due == tick) begin
      it = sb.pop_front();
      ev = it.rd && !oe_n;
      ed = ev ? it.d : 36'h0;
      checks++;
      if (dout_vld !== ev || dout !== ed) begin
        fails++;
        $display("FAIL %s tick %0d: vld=%0b dout=%h expected vld=%0b dout=%h",
                 it.tag, tick, dout_vld, dout, ev, ed);
      end
    end
  end

  task automatic rd(bit adv, logic [AW-1:0] a, string tag, bit oe = 0);
    drive(0, adv, SEL, 1, 4'hF, oe, a, 36'h0, tag);
  endtask

  task automatic nop(string tag, logic [35:0] d = 36'h0, logic [3:0] bw = 4'hF, bit oe = 0);
    drive(0, 0, 3'b110, 1, bw, oe, '0, d, tag);
  endtask

  bit done = 0;

  initial begin
    for (int i = 0; i < 64; i++) ref_mem[i] = '0;
    m1_v = 0; m1_wr = 0; m2_v = 0; m1_a = '0; m2_a = '0; last_rd = 0; last_d = '0;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (dout_vld !== 1'b0 || dout !== 36'h0) begin
      fails++;
      $display("FAIL R8 reset: vld=%0b dout=%h expected vld=0 dout=0", dout_vld, dout);
    end
    @(negedge clk); rst_n = 1'b1;

    // R3 R7: burst writes fill words 0..15, data two edges later
    for (int j = 0; j < 18; j++) begin
      if (j < 16)
        drive(0, (j % 4) != 0, SEL, 0, (j >= 2) ? 4'h0 : 4'hF, 0, AW'(j),
              (j >= 2) ? pat(j - 2) : 36'h0, "R3");
      else
        drive(0, 0, 3'b110, 1, 4'h0, 0, '0, pat(j - 2), "R3");
    end
    // R2 R7: burst read from 0, then single reads
    rd(0, 0, "R1"); rd(1, 0, "R7"); rd(1, 0, "R7"); rd(1, 0, "R7");
    rd(0, 9, "R2"); rd(0, 10, "R2");
    // R6: deselects via each enable, then continued deselect
    drive(0, 0, 3'b011, 1, 4'hF, 0, 6'd11, 36'h0, "R6");
    drive(0, 0, 3'b000, 1, 4'hF, 0, 6'd11, 36'h0, "R6");
    drive(0, 1, SEL, 1, 4'hF, 0, 6'd11, 36'h0, "R6");
    drive(0, 0, 3'b111, 1, 4'hF, 0, 6'd11, 36'h0, "R10");
    nop("R10");
    // R7: wrap inside a group 14,15,12,13
    rd(0, 14, "R7"); rd(1, 0, "R7"); rd(1, 0, "R7"); rd(1, 0, "R7");
    // R9: read lands on the edge where the pending write takes lanes 0 and 2
    drive(0, 0, SEL, 0, 4'hF, 0, 6'd5, 36'h0, "R1");
    rd(0, 5, "R10");
    drive(0, 0, SEL, 1, 4'b1010, 0, 6'd7, 36'hA_BCDE_F012, "R9");
    rd(0, 5, "R9");
    rd(0, 7, "R5");
    // R5: aborted write to 6
    drive(0, 0, SEL, 0, 4'hF, 0, 6'd6, 36'h0, "R5");
    nop("R5"); nop("R5", 36'hF_FFFF_FFFF, 4'hF);
    rd(0, 6, "R5"); nop("R5");
    // R7 R5: continued write, second beat aborted
    drive(0, 0, SEL, 0, 4'hF, 0, 6'd8, 36'h0, "R7");
    drive(0, 1, SEL, 0, 4'hF, 0, 6'd0, 36'h0, "R7");
    nop("R7", 36'h1_2345_6789, 4'h0);
    nop("R7", 36'hE_EEEE_EEEE, 4'hF);
    rd(0, 8, "R7"); rd(0, 9, "R5"); nop("R5");
    // R4: stall holds output and ignores a write command
    rd(0, 1, "R4");
    drive(1, 0, SEL, 0, 4'h0, 0, 6'd2, 36'h0_DEAD_BEEF, "R4");
    drive(1, 0, SEL, 0, 4'h0, 0, 6'd2, 36'h0_DEAD_BEEF, "R4");
    nop("R4", 36'h0_DEAD_BEEF, 4'h0);
    nop("R4"); nop("R4");
    rd(0, 2, "R4"); nop("R4");
    // R8: dummy read and asynchronous gating
    rd(0, 3, "R8");
    nop("R8", 36'h0, 4'hF, 1);
    rd(0, 4, "R8", 1);
    nop("R8", 36'h0, 4'hF, 0);
    nop("R10"); nop("R10");
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule